// File: doc/BRIEF.md
# Four-Step Broadcast Vector Multiply-Accumulate Sequencer

This block executes one chained multiply-accumulate operation over a 16-lane vector of 32-bit signed integers. A single start pulse hands it an accumulator register number, a base source register number and one 128-bit memory word that packs four 32-bit scalars. The block then runs four dependent steps. In step k it takes scalar k, copies it into every lane, multiplies lane by lane with source register base+k, and adds the products into the running accumulator value. When the fourth step completes, the result is written back to the accumulator register.

The vector registers live in a small register file inside the block. A write port loads it from outside and a combinational read port observes it, both addressed by register number. Operands are fetched once, at start. The sequencer then owns the file until write-back, so source reads see the contents the file had when the instruction began.

Top module: `bcast_mac4`

## Requirements
- R1: After reset `busy` and `done` are 0 and every register of the file reads as all zeros.
- R2: While idle, `wr_en` writes `wr_data` into register `wr_sel` at the clock edge. `rd_data` always shows register `rd_sel` combinationally.
- R3: For every lane l, the written-back result is acc[l] + s0*src0[l] + s1*src1[l] + s2*src2[l] + s3*src3[l]. Here scalar sk is bits [32k+31:32k] of `mem_word`, srck is register base+k, and lane l occupies bits [32l+31:32l] of a vector.
- R4: Source register numbers wrap modulo the register count, so base+k past the last register continues from register 0.
- R5: `busy` rises in the cycle after an accepted start and stays high for exactly four cycles.
- R6: `done` is high for exactly one cycle, the last cycle of `busy`. The accumulator register holds the result from the next cycle on.
- R7: A `start` pulse while `busy` is high is ignored. Its operands do not affect the result or the timing.
- R8: `wr_en` while `busy` is high is ignored and leaves the target register unchanged. A write in the same cycle as an accepted start is also dropped.
- R9: All lane products and sums keep the low 32 bits and wrap silently on overflow.
- R10: When the accumulator register is also one of the four sources, every step reads the register's value from before the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (accepted when idle) |
| acc_sel | input | 3 | Accumulator register number |
| src_base | input | 3 | First source register number |
| mem_word | input | 128 | Four packed 32-bit scalars, scalar k at bits [32k+31:32k] |
| wr_en | input | 1 | Register file load strobe |
| wr_sel | input | 3 | Register number to load |
| wr_data | input | 512 | Vector to load |
| rd_sel | input | 3 | Register number to observe |
| rd_data | output | 512 | Contents of register `rd_sel` |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse in the write-back cycle |

## Verification
The embedded properties assume a clean synchronous reset and inputs that change only between clock edges. They also assume that a start pulse may come at any time, including while `busy` is high. The bench drives every input on the falling edge and sweeps all 64 pairs of accumulator and base register numbers. In some runs it deliberately injects a second start or a register write during `busy`. Expected lane values come from a bench-side copy of the register file, updated only through the accepted writes and write-backs.

// File: rtl/bcast_mac4.sv
module bcast_mac4 #(
  parameter int LANES = 16,
  parameter int LW    = 32,
  parameter int NREG  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [$clog2(NREG)-1:0] acc_sel,
  input  logic [$clog2(NREG)-1:0] src_base,
  input  logic [4*LW-1:0]        mem_word,
  input  logic                   wr_en,
  input  logic [$clog2(NREG)-1:0] wr_sel,
  input  logic [LANES*LW-1:0]    wr_data,
  input  logic [$clog2(NREG)-1:0] rd_sel,
  output logic [LANES*LW-1:0]    rd_data,
  output logic                   busy,
  output logic                   done
);
  localparam int IW = $clog2(NREG);
  localparam int VW = LANES * LW;

  logic [VW-1:0]   rf [NREG];
  logic            busy_q;
  logic [1:0]      step_q;
  logic [IW-1:0]   acc_q, base_q;
  logic [4*LW-1:0] mem_q;
  logic [VW-1:0]   sum_q, sum_nx;
  logic [IW-1:0]   src_sel;
  logic [LW-1:0]   scalar;

  assign src_sel = IW'((32'(base_q) + 32'(step_q)) % NREG);
  assign scalar  = mem_q[32'(step_q)*LW +: LW];
  assign busy    = busy_q;
  assign done    = busy_q && (step_q == 2'd3);
  assign rd_data = rf[rd_sel];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LW-1:0] prod;
    assign prod = scalar * rf[src_sel][l*LW +: LW];
    assign sum_nx[l*LW +: LW] = sum_q[l*LW +: LW] + prod;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      acc_q  <= '0;
      base_q <= '0;
      mem_q  <= '0;
      sum_q  <= '0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q <= 1'b1;
        step_q <= '0;
        acc_q  <= acc_sel;
        base_q <= src_base;
        mem_q  <= mem_word;
        sum_q  <= rf[acc_sel];
      end else if (wr_en) begin
        rf[wr_sel] <= wr_data;
      end
    end else begin
      sum_q  <= sum_nx;
      step_q <= step_q + 2'd1;
      if (done) begin
        rf[acc_q] <= sum_nx;
        busy_q    <= 1'b0;
      end
    end
  end

  p_busy_from_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy);
  p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  p_done_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
  p_operands_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> ($stable(base_q) && $stable(acc_q) && $stable(mem_q)));
  p_write_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done && wr_en && (wr_sel == rd_sel)) |=> $stable(rd_data) || $changed(rd_sel));
endmodule

// File: tb/bcast_mac4_tb.sv
module bcast_mac4_tb;
  localparam int LANES = 16, LW = 32, NREG = 8, VW = LANES * LW;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, wr_en = 1'b0;
  logic [2:0] acc_sel = '0, src_base = '0, wr_sel = '0, rd_sel = '0;
  logic [4*LW-1:0] mem_word = '0;
  logic [VW-1:0] wr_data = '0, rd_data;
  logic busy, done;
  int total = 0, bad = 0;
  logic [31:0] m [NREG][LANES];

  always #4 clk = ~clk;

  bcast_mac4 #(.LANES(LANES), .LW(LW), .NREG(NREG)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .acc_sel(acc_sel), .src_base(src_base),
    .mem_word(mem_word), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .busy(busy), .done(done));

  task automatic chk(input bit ok, input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] model_vec(input int r);
    logic [VW-1:0] v;
    for (int l = 0; l < LANES; l++) v[l*LW +: LW] = m[r][l];
    return v;
  endfunction

  task automatic load(input int r, input logic [VW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 3'(r); wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
    for (int l = 0; l < LANES; l++) m[r][l] = v[l*LW +: LW];
  endtask

  task automatic run(input int a, input int b, input logic [127:0] mw,
                     input bit inj_start, input bit inj_wr, input string req);
    logic [VW-1:0] exp;
    int victim;
    victim = (b + 4) % NREG;
    for (int l = 0; l < LANES; l++) begin
      logic [31:0] s;
      s = m[a][l];
      for (int k = 0; k < 4; k++) s = s + mw[32*k +: 32] * m[(b + k) % NREG][l];
      exp[l*LW +: LW] = s;
    end
    @(negedge clk);
    start = 1'b1; acc_sel = 3'(a); src_base = 3'(b); mem_word = mw;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R5 busy after start", VW'({busy, done}), VW'(2'b10));
    if (inj_start) begin
      start = 1'b1; acc_sel = 3'(victim); src_base = 3'(a); mem_word = ~mw;
    end
    if (inj_wr && victim != a) begin
      wr_en = 1'b1; wr_sel = 3'(victim); wr_data = {LANES{32'hdead_beef}};
    end
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
      chk(busy === 1'b1 && done === (c == 3), "R6 done timing", VW'({busy, done}), VW'({1'b1, c == 3}));
    end
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R5 busy length", VW'({busy, done}), VW'(2'b00));
    rd_sel = 3'(a);
    #1;
    chk(rd_data === exp, req, rd_data, exp);
    for (int l = 0; l < LANES; l++) m[a][l] = exp[l*LW +: LW];
    if (inj_wr && victim != a) begin
      rd_sel = 3'(victim);
      #1;
      chk(rd_data === model_vec(victim), "R8 write during busy ignored", rd_data, model_vec(victim));
    end
    if (inj_start) begin
      @(negedge clk);
      chk(busy === 1'b0, "R7 start during busy ignored", VW'(busy), VW'(0));
    end
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sel = 3'd5;
    #1;
    chk(busy === 1'b0 && done === 1'b0 && rd_data === '0, "R1 reset state", rd_data, '0);

    for (int r = 0; r < NREG; r++) begin
      logic [VW-1:0] v;
      for (int l = 0; l < LANES; l++) v[l*LW +: LW] = 32'(r * 1000003 + l * 7919 - 40000);
      load(r, v);
    end
    for (int r = 0; r < NREG; r++) begin
      rd_sel = 3'(r);
      #1;
      chk(rd_data === model_vec(r), "R2 load and read", rd_data, model_vec(r));
    end

    for (int a = 0; a < NREG; a++) begin
      for (int b = 0; b < NREG; b++) begin
        logic [127:0] mw;
        string req;
        for (int k = 0; k < 4; k++) mw[32*k +: 32] = 32'(a * 37 + b * 11 + k * 5 - 20);
        if (((a - b + NREG) % NREG) < 4) req = "R10 accumulator aliases a source";
        else if (b > 4) req = "R4 source index wraps";
        else req = "R3 four-step result";
        run(a, b, mw, (a + b) % 3 == 0, (a + b) % 3 == 1, req);
      end
    end

    load(0, {LANES{32'd1}});
    load(1, {LANES{32'h7fff_ffff}});
    run(0, 1, {32'd0, 32'd0, 32'd0, 32'd2}, 1'b0, 1'b0, "R9 overflow wraps");
    rd_sel = 3'd0;
    #1;
    chk(rd_data === {LANES{32'hffff_ffff}}, "R9 literal wrap value", rd_data, {LANES{32'hffff_ffff}});

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule